// File: doc/BRIEF.md
# Masked Vector Bit Test Unit

The unit examines a wide data vector through a mask of equal width. It reports three single-bit verdicts about the data bits the mask selects: none of them is set, all of them are set, or they are a mix of set and clear. A full-vector mode ignores the supplied mask and selects every bit, so one operation can tell whether the whole vector is all ones.

The operands are captured on the clock edge at which `in_valid` is high. The three verdicts and `out_valid` appear in the following cycle. When no new operand is captured, the verdicts keep their last values. The verdicts come from a per-lane reduction: each fixed-width lane reports whether any selected bit is one and whether any selected bit is zero, and a merge stage combines the lane reports.

A two-state report sequencer drives `out_valid`. `ST_IDLE` means no result is fresh. `ST_REPORT` means the verdicts belong to the operands captured on the previous edge. The sequencer has four transitions:
- `IDLE_TO_REPORT` fires on `in_valid`.
- `REPORT_HOLD` fires when `in_valid` is high again in `ST_REPORT`.
- `REPORT_TO_IDLE` fires when `in_valid` is low in `ST_REPORT`.
- `IDLE_STAY` covers all other cycles in `ST_IDLE`.

Top module: `masked_bit_test`

## Requirements
- R1: `out_zero` is 1 exactly when the bitwise AND of the captured data and the effective mask is all zero.
- R2: `out_ones` is 1 exactly when every data bit selected by the effective mask is 1, that is, when the AND of the inverted data and the effective mask is all zero.
- R3: `out_mixed` is 1 exactly when `out_zero` and `out_ones` are both 0. It is never 1 together with either of them.
- R4: An all-zero effective mask gives `out_zero`=1, `out_ones`=1 and `out_mixed`=0, whatever the data.
- R5: When `in_full_mode`=1, `in_mask` is ignored and the effective mask is all ones. `out_ones` is then 1 only if every data bit is 1, and `out_zero` is 1 only if every data bit is 0.
- R6: Operands are captured only on a rising edge where `in_valid`=1. While `in_valid` is 0, changes on `in_data`, `in_mask` and `in_full_mode` leave all three verdicts unchanged.
- R7: `out_valid` is 1 in the cycle after each edge where `in_valid`=1. It is 0 after an edge where `in_valid`=0. Back-to-back valid inputs keep it high.
- R8: A synchronous active-high `rst` clears `out_valid`, returns the sequencer to `ST_IDLE`, and clears the captured operands. After reset the verdicts therefore read `out_zero`=1, `out_ones`=1, `out_mixed`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the operands |
| in_data | input | DATA_W (128) | Data vector under test |
| in_mask | input | DATA_W (128) | Bit-select mask |
| in_full_mode | input | 1 | 1: treat the mask as all ones |
| out_valid | output | 1 | Verdicts belong to the operands captured on the previous edge |
| out_zero | output | 1 | Selected bits are all zero |
| out_ones | output | 1 | Selected bits are all one |
| out_mixed | output | 1 | Selected bits hold both values |

## Verification
The assertions check the following on every cycle:
- the mutual exclusion of the mixed verdict with the other two;
- the zero and ones verdicts against the operands sampled one edge earlier, including the empty-mask and full-vector cases;
- the one-cycle valid timing;
- the stability of the verdicts when nothing is captured.

Some behaviours only the bench scenarios can show:
- that mask changes are ignored in full-vector mode;
- the reset values of the verdicts;
- correct results across many random data and mask densities, including masks that select only a single bit.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    localparam int DEF_DATA_W = 128;
    localparam int DEF_LANE_W = 32;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic zero;
        logic ones;
        logic mixed;
    } verdict_t;

endpackage

// File: rtl/mbt_operand_stage.sv
module mbt_operand_stage #(
    parameter int DATA_W = mbt_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [DATA_W-1:0] cap_mask,
    input  logic              cap_full,
    output logic [DATA_W-1:0] held_data,
    output logic [DATA_W-1:0] held_mask
);
    localparam logic [DATA_W-1:0] FULL_SEL = {DATA_W{1'b1}};

    logic [DATA_W-1:0] eff_mask;

    // The full-vector mode substitutes the mask before it is stored.
    always_comb begin
        eff_mask = cap_full ? FULL_SEL : cap_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_data <= '0;
            held_mask <= '0;
        end else if (cap_en) begin
            held_data <= cap_data;
            held_mask <= eff_mask;
        end
    end
endmodule

// File: rtl/mbt_lane_reduce.sv
module mbt_lane_reduce #(
    parameter int DATA_W = mbt_pkg::DEF_DATA_W,
    parameter int LANE_W = mbt_pkg::DEF_LANE_W,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] mask,
    output logic [LANES-1:0]  lane_sel_one,
    output logic [LANES-1:0]  lane_sel_zero
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] d_l;
        logic [LANE_W-1:0] m_l;
        always_comb begin
            d_l = data[g*LANE_W +: LANE_W];
            m_l = mask[g*LANE_W +: LANE_W];
            lane_sel_one[g]  = |(d_l & m_l);
            lane_sel_zero[g] = |(~d_l & m_l);
        end
    end
endmodule

// File: rtl/mbt_flag_merge.sv
module mbt_flag_merge #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] lane_sel_one,
    input  logic [LANES-1:0] lane_sel_zero,
    output mbt_pkg::verdict_t verdict
);
    logic any_one;
    logic any_zero;

    always_comb begin
        any_one       = |lane_sel_one;
        any_zero      = |lane_sel_zero;
        verdict.zero  = ~any_one;
        verdict.ones  = ~any_zero;
        verdict.mixed = any_one & any_zero;
    end
endmodule

// File: rtl/masked_bit_test.sv
module masked_bit_test #(
    parameter int DATA_W = mbt_pkg::DEF_DATA_W,
    parameter int LANE_W = mbt_pkg::DEF_LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W-1:0] in_mask,
    input  logic              in_full_mode,
    output logic              out_valid,
    output logic              out_zero,
    output logic              out_ones,
    output logic              out_mixed
);
    import mbt_pkg::*;

    localparam int LANES = DATA_W / LANE_W;

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [DATA_W-1:0] held_data;
    logic [DATA_W-1:0] held_mask;
    logic [LANES-1:0]  sel_one;
    logic [LANES-1:0]  sel_zero;
    verdict_t          verdict;

    mbt_operand_stage #(.DATA_W(DATA_W)) u_ops (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (in_valid),
        .cap_data  (in_data),
        .cap_mask  (in_mask),
        .cap_full  (in_full_mode),
        .held_data (held_data),
        .held_mask (held_mask)
    );

    mbt_lane_reduce #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_reduce (
        .data          (held_data),
        .mask          (held_mask),
        .lane_sel_one  (sel_one),
        .lane_sel_zero (sel_zero)
    );

    mbt_flag_merge #(.LANES(LANES)) u_merge (
        .lane_sel_one  (sel_one),
        .lane_sel_zero (sel_zero),
        .verdict       (verdict)
    );

    // Next-state logic of the report sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_REPORT : ST_IDLE;    // IDLE_TO_REPORT / IDLE_STAY
            ST_REPORT: state_d = in_valid ? ST_REPORT : ST_IDLE;    // REPORT_HOLD / REPORT_TO_IDLE
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        out_valid = (state_q == ST_REPORT);
        out_zero  = verdict.zero;
        out_ones  = verdict.ones;
        out_mixed = verdict.mixed;
    end
endmodule

// File: rtl/masked_bit_test_chk.sv
module masked_bit_test_chk #(
    parameter int DATA_W = mbt_pkg::DEF_DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [DATA_W-1:0] in_mask,
    input logic              in_full_mode,
    input logic              out_valid,
    input logic              out_zero,
    input logic              out_ones,
    input logic              out_mixed
);
    logic [DATA_W-1:0] sel_now;

    always_comb begin
        sel_now = in_full_mode ? {DATA_W{1'b1}} : in_mask;
    end

    AST_ZERO_VERDICT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_zero == ($past(in_data & sel_now) == '0)));   // R1
    AST_ONES_VERDICT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_ones == ($past(~in_data & sel_now) == '0)));  // R2
    AST_MIXED_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(out_mixed && (out_zero || out_ones)));                        // R3
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_full_mode && in_mask == '0) |=> (out_zero && out_ones && !out_mixed)); // R4
    AST_FULL_ONES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_full_mode && (&in_data)) |=> out_ones);         // R5
    AST_HOLD_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable({out_zero, out_ones, out_mixed}));        // R6
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                        // R7
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                      // R7
endmodule

bind masked_bit_test masked_bit_test_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_mask      (in_mask),
    .in_full_mode (in_full_mode),
    .out_valid    (out_valid),
    .out_zero     (out_zero),
    .out_ones     (out_ones),
    .out_mixed    (out_mixed)
);

// File: tb/masked_bit_test_tb.sv
module masked_bit_test_tb;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [W-1:0] in_data;
    logic [W-1:0] in_mask;
    logic         in_full_mode;
    logic         out_valid, out_zero, out_ones, out_mixed;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    masked_bit_test u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_mask      (in_mask),
        .in_full_mode (in_full_mode),
        .out_valid    (out_valid),
        .out_zero     (out_zero),
        .out_ones     (out_ones),
        .out_mixed    (out_mixed)
    );

    function automatic logic [W-1:0] splat(input logic [31:0] v);
        return {4{v}};
    endfunction

    function automatic logic [W-1:0] rnd_vec();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    function automatic logic [2:0] expect_v(input logic [W-1:0] d,
                                            input logic [W-1:0] m,
                                            input logic full);
        logic [W-1:0] em;
        logic z, o;
        em = full ? {W{1'b1}} : m;
        z  = ((d & em) == '0);
        o  = ((~d & em) == '0);
        return {z, o, !z && !o};
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one valid operand, then sample just after the capturing edge.
    task automatic apply(input string req, input logic [W-1:0] d,
                         input logic [W-1:0] m, input logic full);
        in_valid = 1'b1; in_data = d; in_mask = m; in_full_mode = full;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {out_zero, out_ones, out_mixed}, expect_v(d, m, full));
        check({req, " R7 valid"}, {2'b00, out_valid}, 3'b001);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_mask = '0; in_full_mode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check("R8 reset verdicts", {out_zero, out_ones, out_mixed}, 3'b110);
        check("R8 reset valid", {2'b00, out_valid}, 3'b000);

        // Directed cases
        apply("R3 mixed 101/110", splat(32'b101), splat(32'b110), 1'b0);
        check("R3 mixed literal", {out_zero, out_ones, out_mixed}, 3'b001);
        apply("R2 ones with empty mask", {W{1'b1}}, '0, 1'b0);
        apply("R4 zero data empty mask", '0, '0, 1'b0);
        check("R4 literal", {out_zero, out_ones, out_mixed}, 3'b110);
        apply("R2 ones 101/101", splat(32'b101), splat(32'b101), 1'b0);
        check("R2 literal", {out_zero, out_ones, out_mixed}, 3'b010);
        apply("R1 zero 011/100", splat(32'b011), splat(32'b100), 1'b0);
        check("R1 literal", {out_zero, out_ones, out_mixed}, 3'b100);
        apply("R5 full all ones", {W{1'b1}}, '0, 1'b1);
        check("R5 literal ones", {out_zero, out_ones, out_mixed}, 3'b010);
        apply("R5 full one bit clear", {1'b0, {(W-1){1'b1}}}, '0, 1'b1);
        check("R5 literal mix", {out_zero, out_ones, out_mixed}, 3'b001);
        apply("R5 full zero data", '0, {W{1'b1}}, 1'b1);
        apply("R1 single top bit", {1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0);

        // R6/R7: idle cycle with changing inputs
        apply("R6 setup", splat(32'b101), splat(32'b110), 1'b0);
        in_data = '0; in_mask = {W{1'b1}}; in_full_mode = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R6 hold while idle", {out_zero, out_ones, out_mixed}, 3'b001);
        check("R7 valid drops", {2'b00, out_valid}, 3'b000);

        // R7: back-to-back valid
        in_valid = 1'b1; in_data = '0; in_mask = {W{1'b1}}; in_full_mode = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_data = {W{1'b1}};
        check("R7 back-to-back first", {out_zero, out_ones, out_mixed}, 3'b100);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 back-to-back second", {out_zero, out_ones, out_mixed}, 3'b010);
        check("R7 back-to-back valid", {2'b00, out_valid}, 3'b001);

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] d, m;
            logic full;
            d = rnd_vec();
            m = rnd_vec();
            case ($urandom_range(0, 5))
                0: d = '0;
                1: d = {W{1'b1}};
                2: m = m & rnd_vec() & rnd_vec() & rnd_vec();
                3: m = {{(W-1){1'b0}}, 1'b1} << $urandom_range(0, W-1);
                4: d = d | ~m;
                default: ;
            endcase
            full = ($urandom_range(0, 7) == 0);
            apply("R1 R2 R3 R5 random", d, m, full);
        end

        // R8: reset mid-run
        apply("R8 pre-reset", splat(32'b101), splat(32'b110), 1'b0);
        rst = 1'b1; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R8 mid reset verdicts", {out_zero, out_ones, out_mixed}, 3'b110);
        check("R8 mid reset valid", {2'b00, out_valid}, 3'b000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule